// File: doc/BRIEF.md
# Max-Min Fair Rate Allocator

This block divides one shared link capacity among a fixed set of flows by the max-min rule. Software-facing logic (or another block) loads one requested rate per flow through a simple write port, presents the total capacity, and pulses `start`. The engine then runs one round per flow. In each round it picks the smallest request among the flows that have no grant yet. It compares that request with an equal split of the capacity still unallocated over the flows still waiting. The flow receives whichever of the two is smaller.

Each grant lowers the remaining capacity by the amount granted and the waiting count by one. Small requesters are therefore satisfied in full, and the capacity they leave over is shared equally among the larger ones. The equal split is computed by an iterative restoring divider, and the quotient is truncated. All rates are unsigned fixed point, 16 bits wide with 8 fractional bits by default, so 1.0 is the value 256. Each grant is announced on a one-cycle strobe with its flow index. When the last round is done, every flow's allocation sits on a flat output bus and `done` is raised.

Top module: `mmf_allocator`

## Requirements
- R1: After reset, `busy`, `done` and `grantValid` are 0 and every allocation on `allocFlat` is 0.
- R2: While `busy` is 0, a cycle with `wrEn` high stores `wrData` as the request of flow `wrIdx`. Writes while `busy` is 1 are ignored, and a later run uses the old request.
- R3: A `start` pulse while `busy` is 0 samples `capIn`, clears all allocations and raises `busy` on the next cycle. A `start` pulse while `busy` is 1 is ignored, and the run continues with its original capacity.
- R4: Each round serves the flow without a grant whose request is smallest. Equal requests go to the lowest flow index. The served index appears on `grantIdx` in the cycle `grantValid` is high.
- R5: The grant equals the request if the request is less than or equal to floor(remaining capacity / remaining flow count). Otherwise it equals that quotient. A zero capacity gives every flow a grant of 0.
- R6: After each grant, the remaining capacity drops by the grant and the waiting count drops by one. A run yields exactly NUM_FLOWS grants, each flow once, on separate cycles.
- R7: With capacity 256 and requests 25, 128, 2560 and 1280 for flows 0 to 3, the allocations are 25, 77, 77 and 77. The grants come in the order 0, 1, 3, 2.
- R8: `done` rises in the cycle after the last grant strobe. It then stays high, with `allocFlat` unchanged, until a `start` is accepted, and it drops in the cycle after that `start`.
- R9: When the requests sum to no more than the capacity, every flow is granted exactly its request.
- R10: The equal share truncates the fractional part of the quotient. With capacity 10 and four requests of 5, the allocations are 2, 2, 3 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Request write strobe |
| wrIdx | input | IDX_W | Flow index for the request write |
| wrData | input | RATE_W | Requested rate, unsigned fixed point |
| capIn | input | RATE_W | Total link capacity, sampled on accepted start |
| start | input | 1 | Begin an allocation run |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Allocations valid, held until next accepted start |
| grantValid | output | 1 | One-cycle strobe per round |
| grantIdx | output | IDX_W | Flow served in the round being announced |
| allocFlat | output | NUM_FLOWS*RATE_W | Allocation of flow k in bits k*RATE_W upward |

## Verification
The properties assume that reset is applied before the first run. They also assume that `start` may arrive in any cycle, including during a run or while `done` is high, because the block must filter it itself. The bench drives `wrIdx` only within the flow range and changes inputs only between clock edges. It deliberately pulses `start` and `wrEn` in the middle of a run, so the claim that these are ignored is exercised rather than assumed.

// File: rtl/mmf_pkg.sv
package mmf_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic init;     // capture capacity, clear served map and allocations
    logic divLoad;  // load divider with remaining capacity / count
    logic divStep;  // one restoring-division step
    logic commit;   // apply the grant of the current round
  } mmf_ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIVIDE,
    ST_COMMIT,
    ST_FINISH
  } mmf_state_e;
endpackage

// File: rtl/mmf_divider.sv
module mmf_divider #(
  parameter int DVD_W = 16,
  parameter int DVS_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             step,
  input  logic [DVD_W-1:0] dividend,
  input  logic [DVS_W-1:0] divisor,
  output logic [DVD_W-1:0] quotient,
  output logic             lastStep
);
  localparam int CNT_W = $clog2(DVD_W) + 1;

  logic [DVD_W-1:0] quoReg;
  logic [DVS_W-1:0] remReg;
  logic [CNT_W-1:0] stepCnt;
  logic [DVS_W:0]   trial;
  logic [DVS_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {remReg, quoReg[DVD_W-1]};
    fits  = trial >= {1'b0, divisor};
    diff  = trial - {1'b0, divisor};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quoReg  <= '0;
      remReg  <= '0;
      stepCnt <= '0;
    end else if (load) begin
      quoReg  <= dividend;
      remReg  <= '0;
      stepCnt <= '0;
    end else if (step) begin
      if (fits) begin
        remReg <= diff[DVS_W-1:0];
        quoReg <= {quoReg[DVD_W-2:0], 1'b1};
      end else begin
        remReg <= trial[DVS_W-1:0];
        quoReg <= {quoReg[DVD_W-2:0], 1'b0};
      end
      stepCnt <= stepCnt + 1'b1;
    end
  end

  assign quotient = quoReg;
  assign lastStep = stepCnt == CNT_W'(DVD_W - 1);
endmodule

// File: rtl/mmf_datapath.sv
module mmf_datapath
  import mmf_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int RATE_W    = 16,
  parameter int IDX_W     = 2,
  parameter int CNT_W     = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  mmf_ctrl_t                   ctrl,
  input  logic                        wrAccept,
  input  logic [IDX_W-1:0]            wrIdx,
  input  logic [RATE_W-1:0]           wrData,
  input  logic [RATE_W-1:0]           capIn,
  output logic                        divLast,
  output logic                        lastFlow,
  output logic                        grantValid,
  output logic [IDX_W-1:0]            grantIdx,
  output logic [NUM_FLOWS*RATE_W-1:0] allocFlat
);
  logic [RATE_W-1:0]    reqReg   [NUM_FLOWS];
  logic [RATE_W-1:0]    allocReg [NUM_FLOWS];
  logic [NUM_FLOWS-1:0] served;
  logic [RATE_W-1:0]    remCap;
  logic [CNT_W-1:0]     remCnt;
  logic [RATE_W-1:0]    share;
  logic [RATE_W-1:0]    minVal;
  logic [IDX_W-1:0]     minIdx;
  logic                 minFound;
  logic [RATE_W-1:0]    grantAmt;

  // Per-flow request, allocation and served-bit storage
  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_flow
    always_ff @(posedge clk) begin
      if (!rstN) begin
        reqReg[g] <= '0;
      end else if (wrAccept && wrIdx == IDX_W'(g)) begin
        reqReg[g] <= wrData;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || ctrl.init) begin
        allocReg[g] <= '0;
        served[g]   <= 1'b0;
      end else if (ctrl.commit && minIdx == IDX_W'(g)) begin
        allocReg[g] <= grantAmt;
        served[g]   <= 1'b1;
      end
    end

    assign allocFlat[g*RATE_W +: RATE_W] = allocReg[g];
  end

  // Smallest request among unserved flows, lowest index on ties
  always_comb begin
    minVal   = '0;
    minIdx   = '0;
    minFound = 1'b0;
    for (int i = 0; i < NUM_FLOWS; i++) begin
      if (!served[i] && (!minFound || reqReg[i] < minVal)) begin
        minFound = 1'b1;
        minVal   = reqReg[i];
        minIdx   = IDX_W'(i);
      end
    end
  end

  mmf_divider #(
    .DVD_W(RATE_W),
    .DVS_W(CNT_W)
  ) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .load    (ctrl.divLoad),
    .step    (ctrl.divStep),
    .dividend(remCap),
    .divisor (remCnt),
    .quotient(share),
    .lastStep(divLast)
  );

  assign grantAmt = (minVal <= share) ? minVal : share;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remCap     <= '0;
      remCnt     <= '0;
      grantValid <= 1'b0;
      grantIdx   <= '0;
    end else begin
      grantValid <= 1'b0;
      if (ctrl.init) begin
        remCap <= capIn;
        remCnt <= CNT_W'(NUM_FLOWS);
      end else if (ctrl.commit) begin
        remCap     <= remCap - grantAmt;
        remCnt     <= remCnt - 1'b1;
        grantValid <= 1'b1;
        grantIdx   <= minIdx;
      end
    end
  end

  assign lastFlow = remCnt == CNT_W'(1);
endmodule

// File: rtl/mmf_control.sv
module mmf_control
  import mmf_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      divLast,
  input  logic      lastFlow,
  output mmf_ctrl_t ctrl,
  output logic      busy,
  output logic      done
);
  mmf_state_e state, stateNext;

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctrl.init = 1'b1;
          stateNext = ST_LOAD;
        end
      end
      ST_LOAD: begin
        ctrl.divLoad = 1'b1;
        stateNext    = ST_DIVIDE;
      end
      ST_DIVIDE: begin
        ctrl.divStep = 1'b1;
        if (divLast) stateNext = ST_COMMIT;
      end
      ST_COMMIT: begin
        ctrl.commit = 1'b1;
        stateNext   = lastFlow ? ST_FINISH : ST_LOAD;
      end
      ST_FINISH: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && start) done <= 1'b0;
      else if (state == ST_FINISH)   done <= 1'b1;
    end
  end

  assign busy = state != ST_IDLE;
endmodule

// File: rtl/mmf_allocator.sv
module mmf_allocator
  import mmf_pkg::*;
#(
  parameter int NUM_FLOWS = 4,
  parameter int RATE_W    = 16,
  localparam int IDX_W    = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
  localparam int CNT_W    = $clog2(NUM_FLOWS + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [IDX_W-1:0]            wrIdx,
  input  logic [RATE_W-1:0]           wrData,
  input  logic [RATE_W-1:0]           capIn,
  input  logic                        start,
  output logic                        busy,
  output logic                        done,
  output logic                        grantValid,
  output logic [IDX_W-1:0]            grantIdx,
  output logic [NUM_FLOWS*RATE_W-1:0] allocFlat
);
  mmf_ctrl_t ctrl;
  logic      divLast;
  logic      lastFlow;

  mmf_control u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .divLast (divLast),
    .lastFlow(lastFlow),
    .ctrl    (ctrl),
    .busy    (busy),
    .done    (done)
  );

  mmf_datapath #(
    .NUM_FLOWS(NUM_FLOWS),
    .RATE_W   (RATE_W),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .wrAccept  (wrEn && !busy),
    .wrIdx     (wrIdx),
    .wrData    (wrData),
    .capIn     (capIn),
    .divLast   (divLast),
    .lastFlow  (lastFlow),
    .grantValid(grantValid),
    .grantIdx  (grantIdx),
    .allocFlat (allocFlat)
  );
endmodule

// File: rtl/mmf_allocator_chk.sv
module mmf_allocator_chk #(
  parameter int NUM_FLOWS = 4,
  parameter int RATE_W    = 16
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        start,
  input logic                        busy,
  input logic                        done,
  input logic                        grantValid,
  input logic [NUM_FLOWS*RATE_W-1:0] allocFlat
);
  localparam int GC_W = $clog2(NUM_FLOWS + 1) + 1;
  logic [GC_W-1:0] grantCnt;

  always_ff @(posedge clk) begin
    if (!rstN || (start && !busy)) grantCnt <= '0;
    else if (grantValid)           grantCnt <= grantCnt + 1'b1;
  end

  // R8: results and activity never overlap
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  // R4: a grant is only announced during a run
  a_r4_grant_in_run: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> busy);

  // R6: grants are on separate cycles
  a_r6_grant_single: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |=> !grantValid);

  // R6: each run ends with exactly one grant per flow
  a_r6_grant_count: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> grantCnt == GC_W'(NUM_FLOWS));

  // R8: done follows the last grant directly
  a_r8_done_after_grant: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(grantValid));

  // R8: done and the results hold until a start is seen
  a_r8_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done && $stable(allocFlat));

  // R3: a start inside a run does not end the run
  a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    start && busy && !grantValid |=> busy);
endmodule

bind mmf_allocator mmf_allocator_chk #(
  .NUM_FLOWS(NUM_FLOWS),
  .RATE_W   (RATE_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .grantValid(grantValid),
  .allocFlat (allocFlat)
);

// File: tb/mmf_allocator_tb.sv
`timescale 1ns/1ps
module mmf_allocator_tb;
  localparam int NF = 4;
  localparam int RW = 16;

  typedef struct packed {
    logic [RW-1:0]          cap;
    logic [NF-1:0][RW-1:0]  req;
    logic [NF-1:0][RW-1:0]  exp;
    logic [NF-1:0][1:0]     ord;
  } vec_t;

  // fields written {flow3, flow2, flow1, flow0}; ord {4th, 3rd, 2nd, 1st grant}
  localparam vec_t VECS [7] = '{
    '{16'd256,   {16'd1280, 16'd2560, 16'd128, 16'd25},   {16'd77, 16'd77, 16'd77, 16'd25},   {2'd2, 2'd3, 2'd1, 2'd0}},
    '{16'd300,   {16'd100, 16'd100, 16'd100, 16'd100},    {16'd75, 16'd75, 16'd75, 16'd75},   {2'd3, 2'd2, 2'd1, 2'd0}},
    '{16'd1000,  {16'd10, 16'd20, 16'd30, 16'd40},        {16'd10, 16'd20, 16'd30, 16'd40},   {2'd0, 2'd1, 2'd2, 2'd3}},
    '{16'd10,    {16'd5, 16'd5, 16'd5, 16'd5},            {16'd3, 16'd3, 16'd2, 16'd2},       {2'd3, 2'd2, 2'd1, 2'd0}},
    '{16'd400,   {16'd300, 16'd100, 16'd500, 16'd100},    {16'd100, 16'd100, 16'd100, 16'd100}, {2'd1, 2'd3, 2'd2, 2'd0}},
    '{16'd0,     {16'd1, 16'd9, 16'd3, 16'd7},            {16'd0, 16'd0, 16'd0, 16'd0},       {2'd2, 2'd0, 2'd1, 2'd3}},
    '{16'd65535, {16'd65535, 16'd65535, 16'd65535, 16'd65535}, {16'd16384, 16'd16384, 16'd16384, 16'd16383}, {2'd3, 2'd2, 2'd1, 2'd0}}
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wrEn = 1'b0;
  logic [1:0]        wrIdx = '0;
  logic [RW-1:0]     wrData = '0;
  logic [RW-1:0]     capIn = '0;
  logic              start = 1'b0;
  logic              busy, done, grantValid;
  logic [1:0]        grantIdx;
  logic [NF*RW-1:0]  allocFlat;

  int checks = 0;
  int errs = 0;
  int gCnt = 0;
  logic [1:0] gOrd [8];
  bit finished = 0;

  always #2.5 clk = ~clk;

  mmf_allocator #(.NUM_FLOWS(NF), .RATE_W(RW)) u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .capIn(capIn), .start(start), .busy(busy), .done(done),
    .grantValid(grantValid), .grantIdx(grantIdx), .allocFlat(allocFlat)
  );

  always @(negedge clk) begin
    if (rstN && grantValid) begin
      if (gCnt < 8) gOrd[gCnt] = grantIdx;
      gCnt = gCnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string tagOf(input int v);
    case (v)
      0: return "R7";
      1: return "R4";
      2: return "R9";
      3: return "R10";
      4: return "R5";
      5: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic writeReq(input int idx, input logic [RW-1:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = idx[1:0]; wrData = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic pulseStart(input logic [RW-1:0] cap);
    @(negedge clk);
    capIn = cap; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    int n = 0;
    while (!done && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (!done) chk("R8 timeout", 0, 1);
  endtask

  function automatic logic [RW-1:0] allocOf(input int f);
    return allocFlat[f*RW +: RW];
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 grantValid", grantValid, 0);
    chk("R1 alloc", allocFlat == '0, 1);

    for (int v = 0; v < 7; v++) begin
      for (int f = 0; f < NF; f++) writeReq(f, VECS[v].req[f]);
      gCnt = 0;
      pulseStart(VECS[v].cap);
      chk("R3 busy after start", busy, 1);
      waitDone();
      for (int f = 0; f < NF; f++) chk(tagOf(v), allocOf(f), VECS[v].exp[f]);
      chk("R6 grant count", gCnt, NF);
      for (int k = 0; k < NF; k++) chk({tagOf(v), " order"}, gOrd[k], VECS[v].ord[k]);
    end

    // R2/R3: writes and start during a run are ignored
    for (int f = 0; f < NF; f++) writeReq(f, VECS[0].req[f]);
    gCnt = 0;
    pulseStart(16'd256);
    repeat (5) @(negedge clk);
    writeReq(0, 16'd999);
    pulseStart(16'd0);
    waitDone();
    for (int f = 0; f < NF; f++) chk("R3 start ignored", allocOf(f), VECS[0].exp[f]);
    chk("R6 grant count", gCnt, NF);

    // R8: done and results hold while idle
    writeReq(0, 16'd999);
    repeat (20) @(negedge clk);
    chk("R8 done held", done, 1);
    for (int f = 0; f < NF; f++) chk("R8 alloc held", allocOf(f), VECS[0].exp[f]);

    // R2: idle write takes effect; R8 done drops after start
    pulseStart(16'd256);
    chk("R8 done cleared", done, 0);
    chk("R3 busy", busy, 1);
    waitDone();
    for (int f = 0; f < NF; f++) chk("R2 idle write used", allocOf(f), 16'd64);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule